// File: doc/BRIEF.md
# Serially Configured Four-Input Logic Cell

A single programmable logic cell. A four-input lookup table forms one function of the four data inputs. A small carry stage can fold the carry input into that function and produce a carry for the next cell. A user flip-flop captures either that function or a separate bypass input. One output is chosen by a configuration bit, the registered output is always available, and a third output carries the carry to the next cell.

All programming state sits in a single serial-in/parallel-out chain of 19 bits. The chain is loaded one bit per rising edge of a dedicated configuration clock while the configuration enable is high. The state is loaded once before use and left unchanged while the cell runs on its user clock.

Top module: `cfg_logic_cell`

## Requirements
- R1: With carry mode off and output select 0, `main_o` equals truth-table bit number `data_i` (read as an unsigned index, `data_i[3]` most significant), with no clock delay.
- R2: On each rising `cfg_clk_i` edge with `cfg_en_i` high, `cfg_din_i` enters the chain. After 19 such edges, the first bit shifted in is truth-table bit 15. The next 15 bits are truth-table bits 14 down to 0. Then come output select, flip-flop source select, and carry enable.
- R3: While `cfg_en_i` is low, the chain and so the cell's function are unchanged, whatever `cfg_clk_i` does.
- R4: With output select 1, `main_o` equals `reg_o`.
- R5: On each rising `clk_i` edge, `reg_o` takes the cell function when the flip-flop source select is 0, and `byp_i` when it is 1. With source select 1, `main_o` can carry the cell function while `reg_o` follows an unrelated input.
- R6: With carry enable 1, the cell function is the lookup result XOR `cin_i`. `cout_o` is the majority of `data_i[0]`, `data_i[1]` and `cin_i`.
- R7: With carry enable 0, the cell function is the lookup result and `cout_o` equals `cin_i`.
- R8: While `rst_ni` is low, the chain and `reg_o` are cleared asynchronously. The cell then drives `main_o` = 0 and `cout_o` = `cin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock for the flip-flop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_clk_i | input | 1 | Configuration shift clock |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_din_i | input | 1 | Serial configuration data |
| data_i | input | 4 | Lookup-table select inputs |
| byp_i | input | 1 | Direct input to the flip-flop |
| cin_i | input | 1 | Carry from the previous cell |
| main_o | output | 1 | Selected output, combinational or registered |
| reg_o | output | 1 | Flip-flop output |
| cout_o | output | 1 | Carry to the next cell |

## Verification
The checks on the flip-flop source and the output select assume the configuration is static while `clk_i` runs. They compare the flip-flop against the select bits held in the chain at the previous user edge. The bench honours this by loading the chain only between scenarios, with `cfg_en_i` low otherwise. The chain checks assume `cfg_en_i` and `cfg_din_i` never change at a `cfg_clk_i` edge. The bench sets them half a configuration period before each rising edge, and it drives data inputs on the falling edge of `clk_i`.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned LC_K    = 4;
  localparam int unsigned LC_CTRL = 3;

  // Control bits at the shallow end of the chain, order fixed by the load sequence
  typedef struct packed {
    logic out_sel;
    logic ff_byp;
    logic carry_en;
  } lc_ctrl_t;
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int unsigned W = 19
) (
  input  logic         cfg_clk_i,
  input  logic         rst_ni,
  input  logic         cfg_en_i,
  input  logic         cfg_din_i,
  output logic [W-1:0] cfg_q_o
);
  logic [W-1:0] q;

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (cfg_en_i) q <= {q[W-2:0], cfg_din_i};
  end

  assign cfg_q_o = q;
endmodule

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int unsigned K = 4,
  localparam int unsigned N = 1 << K
) (
  input  logic [N-1:0] tt_i,
  input  logic [K-1:0] sel_i,
  output logic         y_o
);
  // Binary mux tree in heap order; leaf N-1+i holds truth bit i
  logic [2*N-2:0] node;

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[N-1+i] = tt_i[i];
  end

  for (genvar d = 0; d < K; d++) begin : g_lvl
    for (genvar j = 0; j < (1 << d); j++) begin : g_mux
      localparam int unsigned IDX = (1 << d) - 1 + j;
      assign node[IDX] = sel_i[K-1-d] ? node[2*IDX+2] : node[2*IDX+1];
    end
  end

  assign y_o = node[0];
endmodule

// File: rtl/lc_carry.sv
module lc_carry (
  input  logic en_i,
  input  logic lut_i,
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic f_o,
  output logic cout_o
);
  always_comb begin
    if (en_i) begin
      f_o    = lut_i ^ cin_i;
      cout_o = (a_i & b_i) | (a_i & cin_i) | (b_i & cin_i);
    end else begin
      f_o    = lut_i;
      cout_o = cin_i;
    end
  end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
  parameter int unsigned K = lc_pkg::LC_K,
  localparam int unsigned LUT_W = 1 << K,
  localparam int unsigned CFG_W = LUT_W + lc_pkg::LC_CTRL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_clk_i,
  input  logic         cfg_en_i,
  input  logic         cfg_din_i,
  input  logic [K-1:0] data_i,
  input  logic         byp_i,
  input  logic         cin_i,
  output logic         main_o,
  output logic         reg_o,
  output logic         cout_o
);
  import lc_pkg::*;

  logic [CFG_W-1:0] cfg_q;
  logic [LUT_W-1:0] tt;
  lc_ctrl_t         ctrl;
  logic             lut_y, fn, ff_q;

  lc_cfg_chain #(.W(CFG_W)) u_chain (
    .cfg_clk_i (cfg_clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .cfg_din_i (cfg_din_i),
    .cfg_q_o   (cfg_q)
  );

  assign tt   = cfg_q[CFG_W-1:LC_CTRL];
  assign ctrl = lc_ctrl_t'(cfg_q[LC_CTRL-1:0]);

  lc_lut #(.K(K)) u_lut (
    .tt_i  (tt),
    .sel_i (data_i),
    .y_o   (lut_y)
  );

  lc_carry u_carry (
    .en_i   (ctrl.carry_en),
    .lut_i  (lut_y),
    .a_i    (data_i[0]),
    .b_i    (data_i[1]),
    .cin_i  (cin_i),
    .f_o    (fn),
    .cout_o (cout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 1'b0;
    else         ff_q <= ctrl.ff_byp ? byp_i : fn;
  end

  assign reg_o  = ff_q;
  assign main_o = ctrl.out_sel ? ff_q : fn;
endmodule

// File: rtl/lc_cell_chk.sv
module lc_cell_chk #(
  parameter int unsigned K = 4,
  parameter int unsigned CFG_W = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_clk_i,
  input logic             cfg_en_i,
  input logic             cfg_din_i,
  input logic [K-1:0]     data_i,
  input logic             byp_i,
  input logic             cin_i,
  input logic             main_o,
  input logic             reg_o,
  input logic             cout_o,
  input logic [CFG_W-1:0] cfg_q
);
  // R2
  shift_in_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (cfg_q[0] == $past(cfg_din_i)) &&
                 (cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0])));

  // R3
  hold_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q));

  // R4
  out_reg_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cfg_q[2] |-> main_o == reg_o);

  // R5
  byp_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[1] |=> reg_o == $past(byp_i));

  // R7
  carry_pass_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !cfg_q[0] |-> cout_o == cin_i);

  // R8
  always_comb begin
    if (!rst_ni) begin
      rst_reg_chk: assert (reg_o == 1'b0 || $isunknown(reg_o));
    end
  end
endmodule

bind cfg_logic_cell lc_cell_chk #(.K(K), .CFG_W(CFG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_clk_i (cfg_clk_i),
  .cfg_en_i  (cfg_en_i),
  .cfg_din_i (cfg_din_i),
  .data_i    (data_i),
  .byp_i     (byp_i),
  .cin_i     (cin_i),
  .main_o    (main_o),
  .reg_o     (reg_o),
  .cout_o    (cout_o),
  .cfg_q     (cfg_q)
);

// File: tb/tb_cfg_logic_cell.sv
`timescale 1ns/1ps
module tb_cfg_logic_cell;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_clk_i = 1'b0, cfg_en_i = 1'b0, cfg_din_i = 1'b0;
  logic [3:0] data_i = '0;
  logic byp_i = 1'b0, cin_i = 1'b0;
  logic main_o, reg_o, cout_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cfg_logic_cell dut (.*);

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic shift_bit(logic b, logic en);
    cfg_en_i = en; cfg_din_i = b;
    #2 cfg_clk_i = 1'b1;
    #2 cfg_clk_i = 1'b0;
  endtask

  task automatic load_cfg(logic [15:0] tt, logic osel, logic fsrc, logic cen);
    for (int i = 15; i >= 0; i--) shift_bit(tt[i], 1'b1);
    shift_bit(osel, 1'b1);
    shift_bit(fsrc, 1'b1);
    shift_bit(cen, 1'b1);
    cfg_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    cin_i = 1'b1; data_i = 4'hF; #1;
    chk("R8 main", main_o, 1'b0);
    chk("R8 reg", reg_o, 1'b0);
    chk("R8 cout", cout_o, 1'b1);
    cin_i = 1'b0;
  endtask

  task automatic t_lut(logic [15:0] tt, string tag);
    load_cfg(tt, 1'b0, 1'b0, 1'b0);
    for (int v = 0; v < 16; v++) begin
      data_i = 4'(v); #1;
      chk(tag, main_o, tt[v]);
    end
  endtask

  task automatic t_hold();
    logic [15:0] tt = 16'h3C5A;
    load_cfg(tt, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) shift_bit(1'b1, 1'b0);
    for (int v = 0; v < 16; v++) begin
      data_i = 4'(v); #1;
      chk("R3 hold", main_o, tt[v]);
    end
  endtask

  task automatic t_ff_fn();
    logic [15:0] tt = 16'h6996;
    load_cfg(tt, 1'b1, 1'b0, 1'b0);
    for (int v = 0; v < 16; v += 3) begin
      data_i = 4'(v);
      @(posedge clk_i); @(negedge clk_i);
      chk("R5 reg fn", reg_o, tt[v]);
      chk("R4 main=reg", main_o, tt[v]);
    end
  endtask

  task automatic t_bypass();
    load_cfg(16'h8000, 1'b0, 1'b1, 1'b0);
    data_i = 4'hF; byp_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk("R5 byp main", main_o, 1'b1);
    chk("R5 byp reg", reg_o, 1'b0);
    data_i = 4'h0; byp_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk("R5 byp main", main_o, 1'b0);
    chk("R5 byp reg", reg_o, 1'b1);
    byp_i = 1'b0;
  endtask

  task automatic t_carry_on();
    load_cfg(16'hAAAA, 1'b0, 1'b0, 1'b1);
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      data_i = {2'b10, v[1:0]}; cin_i = v[2]; #1;
      a = v[0]; b = v[1]; c = v[2];
      chk("R6 sum", main_o, a ^ c);
      chk("R6 cout", cout_o, (a & b) | (a & c) | (b & c));
    end
    cin_i = 1'b0;
  endtask

  task automatic t_carry_off();
    load_cfg(16'hAAAA, 1'b0, 1'b0, 1'b0);
    for (int v = 0; v < 4; v++) begin
      data_i = 4'b0011; cin_i = v[0]; #1;
      chk("R7 cout", cout_o, v[0]);
      chk("R7 fn", main_o, 1'b1);
    end
    cin_i = 1'b0;
  endtask

  initial begin
    #12 t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    t_lut(16'h8000, "R2 order");
    t_lut(16'h0001, "R2 order");
    t_lut(16'hE81F, "R1 lut");
    t_hold();
    t_ff_fn();
    t_bypass();
    t_carry_on();
    t_carry_off();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule